// File: doc/BRIEF.md
# 8b/10b Serial Transmit Lane

This block is the transmit datapath of one serial lane. It takes one 10-bit parallel word per character time and sends it out one bit per clock, least significant bit first. Normally the block encodes the word with the 8b/10b transmission code that gigabit Ethernet uses. It builds each character from a 5b/6b sub-block and a 3b/4b sub-block, and it tracks running disparity from one character to the next.

A runtime bypass select lets a word that is already encoded skip the encoder. The 10 input bits then go to the serializer unchanged. The caller pulses a word strobe once every 10 clocks. The new character is loaded in the same cycle in which the last bit of the previous character is shifted out, so the serial stream has no gaps.

Top module: `serial_8b10b_tx`

## Requirements
- R1: In encoded mode, `word_in[7:0]` is the byte HGFEDCBA with bit 0 as A, that is, x = `word_in[4:0]` and y = `word_in[7:5]`. With the control flag at 0, the character sent is the standard data character D.x.y for the current running disparity.
- R2: In encoded mode, `word_in[8]` = 1 requests a special character. The valid requests are K28.0 to K28.7 and K23.7, K27.7, K29.7 and K30.7, and each is sent as its standard control code with `code_err` = 0.
- R3: In encoded mode, `word_in[9]` has no effect: a word with bit 9 set is encoded as if bit 9 were 0.
- R4: With `bypass` = 1 at the strobe, the 10 input bits are sent unchanged, and `code_err` reads 0 for that word.
- R5: Character bit positions 0 to 9 hold code bits a, b, c, d, e, i, f, g, h, j, and position 0 is sent first.
- R6: Running disparity is negative after reset, and `disp_pos` shows it as 1 for positive. Every encoded character has 4, 5 or 6 ones. A character with 6 ones is sent only from negative disparity, a character with 4 ones only from positive disparity, and `disp_pos` follows the result.
- R7: A bypassed word leaves the running disparity unchanged.
- R8: A control request for any byte not listed in R2 sets `code_err` for that word, and the block sends the data encoding of the byte instead.
- R9: For D.x.7, the alternate 3b/4b code is used when the disparity is negative with x in {17, 18, 20}, or positive with x in {11, 13, 14}. The encoded stream never holds more than five equal bits in a row.
- R10: A strobe at a rising edge loads the word, and its bit 0 appears on `ser_out` right after that edge. With a strobe every 10 clocks, the characters follow one another with no idle bits.
- R11: K28.5 is sent as a,b,c,d,e,i,f,g,h,j = 0011111010 from negative disparity and 1100000101 from positive disparity, so it carries the seven-bit comma.
- R12: During and right after reset, `ser_out`, `code_err` and `disp_pos` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_stb | input | 1 | Load strobe, asserted once every 10 clocks |
| bypass | input | 1 | 1: send word_in as a pre-encoded character |
| word_in | input | 10 | Parallel word: {unused, control flag, byte} or a raw 10-bit character |
| ser_out | output | 1 | Serial output, bit a first |
| code_err | output | 1 | The last loaded word was an invalid control request |
| disp_pos | output | 1 | Running disparity after the last encoded character (1 = positive) |

## Verification
The alternate D.x.7 codes are the hardest case to reach from the ports. Each one needs a specific disparity at the boundary between the 6-bit and 4-bit sub-blocks, and that disparity depends on every character sent before it. The bench keeps its own disparity, worked out from the number of ones it receives. Before D17.7 or D11.7 it sends K28.5 characters, which always flip the disparity, until it reaches the sign it needs. It then checks the fghj bits and the longest run of equal bits. The bench decodes every received character using its own disparity, so each character, K28.5 included, is also checked from both signs.

// File: rtl/serial_8b10b_tx.sv
module serial_8b10b_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_stb,
  input  logic       bypass,
  input  logic [9:0] word_in,
  output logic       ser_out,
  output logic       code_err,
  output logic       disp_pos
);
  localparam int CW = 10;

  // code tables written MSB-first as abcdei / fghj, negative-disparity column
  function automatic logic [5:0] six_neg(input logic [4:0] v);
    case (v)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] four_neg(input logic [2:0] v);
    case (v)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [3:0] kfour_neg(input logic [2:0] v);
    case (v)
      3'd0: return 4'b1011;  3'd1: return 4'b0110;
      3'd2: return 4'b1010;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b0101;
      3'd6: return 4'b1001;  default: return 4'b0111;
    endcase
  endfunction

  logic [CW-1:0] shreg;
  logic          rd;
  logic [4:0]    x;
  logic [2:0]    y;
  logic          kreq, k28, kalt, k_ok;
  logic [5:0]    s6n, s6;
  logic [3:0]    f4n, f4;
  logic          flip6, flip4, rd_mid, rd_end, use_a7;
  logic [CW-1:0] enc;

  assign x    = word_in[4:0];
  assign y    = word_in[7:5];
  assign kreq = word_in[8];
  assign k28  = kreq && (x == 5'd28);
  assign kalt = kreq && (y == 3'd7) && (x inside {5'd23, 5'd27, 5'd29, 5'd30});
  assign k_ok = k28 || kalt;

  assign s6n   = k28 ? 6'b001111 : six_neg(x);
  assign flip6 = ($countones(s6n) != 3) || (!k28 && x == 5'd7);
  assign s6    = (rd && flip6) ? ~s6n : s6n;
  assign rd_mid = ($countones(s6) > 3) ? 1'b1 : ($countones(s6) < 3) ? 1'b0 : rd;

  assign use_a7 = kalt || (!k28 && y == 3'd7 &&
                  ((!rd_mid && (x inside {5'd17, 5'd18, 5'd20})) ||
                   ( rd_mid && (x inside {5'd11, 5'd13, 5'd14}))));
  assign f4n   = k28 ? kfour_neg(y) : use_a7 ? 4'b0111 : four_neg(y);
  assign flip4 = k28 || ($countones(f4n) != 2) || (y == 3'd3);
  assign f4    = (rd_mid && flip4) ? ~f4n : f4n;
  assign rd_end = ($countones(f4) > 2) ? 1'b1 : ($countones(f4) < 2) ? 1'b0 : rd_mid;

  assign enc = {f4[0], f4[1], f4[2], f4[3], s6[0], s6[1], s6[2], s6[3], s6[4], s6[5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rd       <= 1'b0;
      code_err <= 1'b0;
    end else if (word_stb) begin
      shreg    <= bypass ? word_in : enc;
      code_err <= !bypass && kreq && !k_ok;
      if (!bypass) rd <= rd_end;
    end else begin
      shreg <= {1'b0, shreg[CW-1:1]};
    end
  end

  assign ser_out  = shreg[0];
  assign disp_pos = rd;

  a_r6_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && !bypass |=> ($countones(shreg) >= 4 && $countones(shreg) <= 6));
  a_r6_from_neg: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && !bypass && !disp_pos |=> $countones(shreg) >= 5);
  a_r6_from_pos: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && !bypass && disp_pos |=> $countones(shreg) <= 5);
  a_r4_raw_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && bypass |=> ser_out == $past(word_in[0]));
  a_r8_bad_k_flag: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && !bypass && word_in[8] && word_in[4:0] == 5'd0 |=> code_err);
  a_r11_comma: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && !bypass && word_in[8:0] == 9'h1BC |=>
    (shreg[6:0] == 7'b1111100 || shreg[6:0] == 7'b0000011));
endmodule

// File: tb/test_serial_8b10b_tx.sv
module test_serial_8b10b_tx;
  logic clk = 1'b0, rst_n = 1'b0, word_stb = 1'b0, bypass = 1'b0;
  logic [9:0] word_in = '0;
  logic ser_out, code_err, disp_pos;

  serial_8b10b_tx i_serial_8b10b_tx (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .bypass(bypass),
    .word_in(word_in), .ser_out(ser_out), .code_err(code_err), .disp_pos(disp_pos));

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int run_len = 0, last_bit = -1, max_run = 0;
  logic rd_b = 1'b0;

  function automatic logic [5:0] t6(input logic [4:0] v);
    logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
      6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100,
      6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010,
      6'b011010, 6'b111010, 6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
      6'b011110, 6'b101011};
    return t[v];
  endfunction

  function automatic logic [3:0] t4(input logic [2:0] v);
    logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return t[v];
  endfunction

  function automatic logic [3:0] tk4(input logic [2:0] v);
    logic [3:0] t [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100, 4'b1101, 4'b0101, 4'b1001, 4'b0111};
    return t[v];
  endfunction

  function automatic bit kvalid(input logic [7:0] b);
    return (b[4:0] == 5'd28) ||
           (b[7:5] == 3'd7 && (b[4:0] inside {5'd23, 5'd27, 5'd29, 5'd30}));
  endfunction

  // decode one received character using the bench's own disparity
  function automatic void dec(input logic [9:0] ch, input logic rdi,
                              output logic [7:0] b, output logic k,
                              output logic ok, output logic rdo);
    logic [5:0] c6 = {ch[0], ch[1], ch[2], ch[3], ch[4], ch[5]};
    logic [3:0] c4 = {ch[6], ch[7], ch[8], ch[9]};
    logic [4:0] xv = '0;
    logic [2:0] yv = '0;
    bit f6 = 0, f4 = 0, is28 = 0, a7req, kx;
    logic rdm;
    int n;
    k = 1'b0;
    if (c6 == (rdi ? 6'b110000 : 6'b001111)) begin xv = 5'd28; is28 = 1; f6 = 1; end
    else for (int i = 0; i < 32; i++) begin
      logic [5:0] l = t6(i[4:0]);
      logic [5:0] e = (rdi && ($countones(l) != 3 || i == 7)) ? ~l : l;
      if (e == c6) begin xv = i[4:0]; f6 = 1; end
    end
    n = $countones(c6);
    rdm = (n > 3) ? 1'b1 : (n < 3) ? 1'b0 : rdi;
    if (is28) begin
      for (int j = 0; j < 8; j++)
        if ((rdm ? ~tk4(j[2:0]) : tk4(j[2:0])) == c4) begin yv = j[2:0]; f4 = 1; end
      k = 1'b1;
    end else begin
      a7req = (!rdm && (xv inside {5'd17, 5'd18, 5'd20})) || (rdm && (xv inside {5'd11, 5'd13, 5'd14}));
      kx = xv inside {5'd23, 5'd27, 5'd29, 5'd30};
      for (int j = 0; j < 8; j++) begin
        logic [3:0] l = t4(j[2:0]);
        logic [3:0] e;
        if (j == 7 && a7req) e = rdm ? 4'b1000 : 4'b0111;
        else e = (rdm && ($countones(l) != 2 || j == 3)) ? ~l : l;
        if (e == c4) begin yv = j[2:0]; f4 = 1; end
      end
      if (!f4 && kx && c4 == (rdm ? 4'b1000 : 4'b0111)) begin yv = 3'd7; f4 = 1; k = 1'b1; end
    end
    b = {yv, xv};
    ok = f6 && f4;
    n = $countones(ch);
    rdo = (n > 5) ? 1'b1 : (n < 5) ? 1'b0 : rdi;
  endfunction

  task automatic chk(input bit cond, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the 10th bit
  task automatic xmit(input logic [9:0] w, input logic byp,
                      output logic [9:0] ch, output logic err, output logic dp);
    word_in = w; bypass = byp; word_stb = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ch[i] = ser_out;
      if (i == 0) begin word_stb = 1'b0; err = code_err; dp = disp_pos; end
      if (byp) begin run_len = 0; last_bit = -1; end
      else begin
        if (int'(ser_out) == last_bit) run_len++;
        else begin run_len = 1; last_bit = int'(ser_out); end
        if (run_len > max_run) max_run = run_len;
      end
    end
  endtask

  task automatic send_enc(input logic [9:0] w, input string req, output logic [9:0] ch);
    logic err, dp, k, ok, rdn;
    logic [7:0] b;
    int n;
    logic kexp = w[8] && kvalid(w[7:0]);
    xmit(w, 1'b0, ch, err, dp);
    dec(ch, rd_b, b, k, ok, rdn);
    chk(ok && b == w[7:0] && k == kexp, req, {5'(0), k, ch}, {7'(0), kexp, w[7:0]});
    chk(err == (w[8] && !kvalid(w[7:0])), "R8 code_err", 16'(err), 16'(w[8] && !kvalid(w[7:0])));
    n = $countones(ch);
    chk(n >= 4 && n <= 6 && !(n == 6 && rd_b) && !(n == 4 && !rd_b), "R6 balance",
        16'(n), 16'(5));
    chk(dp == rdn, "R6 disp_pos", 16'(dp), 16'(rdn));
    rd_b = rdn;
  endtask

  task automatic t_reset;
    chk(ser_out == 1'b0 && code_err == 1'b0, "R12 outputs at reset", {ser_out, code_err}, 0);
    chk(disp_pos == 1'b0, "R6 R12 disparity negative at reset", 16'(disp_pos), 0);
  endtask

  task automatic t_comma;
    logic [9:0] ch;
    send_enc(10'h1BC, "R11 K28.5", ch);
    chk(ch == 10'b0101111100, "R11 R5 K28.5 from negative", 16'(ch), 16'(10'b0101111100));
    send_enc(10'h1BC, "R11 K28.5", ch);
    chk(ch == 10'b1010000011, "R11 R5 K28.5 from positive", 16'(ch), 16'(10'b1010000011));
  endtask

  task automatic t_all_data;
    logic [9:0] ch;
    for (int i = 0; i < 256; i++) send_enc({2'b00, i[7:0]}, "R1 R10 data byte", ch);
  endtask

  task automatic t_kcodes;
    logic [9:0] ch;
    for (int r = 0; r < 2; r++) begin
      for (int j = 0; j < 8; j++) send_enc({2'b01, j[2:0], 5'd28}, "R2 K28.y", ch);
      send_enc(10'h1F7, "R2 K23.7", ch);
      send_enc(10'h1FB, "R2 K27.7", ch);
      send_enc(10'h1FD, "R2 K29.7", ch);
      send_enc(10'h1FE, "R2 K30.7", ch);
    end
  endtask

  task automatic t_bad_k;
    logic [9:0] ch;
    send_enc(10'h100, "R8 bad K 00 sent as data", ch);
    send_enc(10'h155, "R8 bad K 55 sent as data", ch);
    send_enc(10'h1EB, "R8 bad K EB sent as data", ch);
    send_enc(10'h000, "R8 flag clears on next word", ch);
  endtask

  task automatic t_bit9;
    logic [9:0] ch;
    send_enc(10'h2A5, "R3 bit9 ignored data", ch);
    send_enc(10'h3BC, "R3 bit9 ignored K28.5", ch);
    send_enc(10'h2FF, "R3 bit9 ignored data FF", ch);
  endtask

  task automatic t_alt7;
    logic [9:0] ch;
    while (rd_b != 1'b0) send_enc(10'h1BC, "R9 steer", ch);
    send_enc(10'h0F1, "R9 D17.7", ch);
    chk(ch[9:6] == 4'b1110, "R9 D17.7 alternate from negative", 16'(ch[9:6]), 16'(4'b1110));
    while (rd_b != 1'b1) send_enc(10'h1BC, "R9 steer", ch);
    send_enc(10'h0EB, "R9 D11.7", ch);
    chk(ch[9:6] == 4'b0001, "R9 D11.7 alternate from positive", 16'(ch[9:6]), 16'(4'b0001));
    while (rd_b != 1'b0) send_enc(10'h1BC, "R9 steer", ch);
    send_enc(10'h0EB, "R9 D11.7 primary", ch);
    chk(ch[9:6] == 4'b0111, "R9 D11.7 primary from negative", 16'(ch[9:6]), 16'(4'b0111));
    chk(max_run <= 5, "R9 run length", 16'(max_run), 16'(5));
  endtask

  task automatic t_bypass;
    logic [9:0] ch;
    logic err, dp;
    logic rd_before = rd_b;
    xmit(10'h3FF, 1'b1, ch, err, dp);
    chk(ch == 10'h3FF && err == 1'b0, "R4 raw 3FF", {5'(0), err, ch}, 16'h3FF);
    chk(dp == rd_before, "R7 disparity held", 16'(dp), 16'(rd_before));
    xmit(10'h000, 1'b1, ch, err, dp);
    chk(ch == 10'h000, "R4 R10 raw 000 right after", 16'(ch), 0);
    xmit(10'h2D3, 1'b1, ch, err, dp);
    chk(ch == 10'h2D3, "R4 R5 raw 2D3 order", 16'(ch), 16'h2D3);
    xmit(10'h100, 1'b1, ch, err, dp);
    chk(ch == 10'h100 && err == 1'b0, "R4 raw with flag bit set", {5'(0), err, ch}, 16'h100);
    chk(dp == rd_before, "R7 disparity held", 16'(dp), 16'(rd_before));
    send_enc(10'h1BC, "R7 encoding resumes", ch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_comma();
    t_all_data();
    t_kcodes();
    t_bad_k();
    t_bit9();
    t_alt7();
    t_bypass();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule